// File: doc/BRIEF.md
# Timed Tuning Command Controller

This block sequences the commands that software issues to a radio tuner front end. Software first selects a command class (measurement, adjustment or tuning) and a variant bit through a configuration write. It then writes a 16-bit target value as two byte writes, low byte first. The high-byte write launches the command. While the command runs, the block reports a busy code. When the command finishes, the block reports a completion code.

Each command lasts a fixed time that depends on its class and variant. The time is counted on a slow reference tick of 32.768 kHz, so the status code is valid only after that time has elapsed. The analog loop can end a command early by raising a converter-limit input. Software can end a command early with an abort strobe.

The block also keeps a tuned flag. A successful tuning command sets it. Power loss, a new tuning launch or the loop leaving its correction range clears it. Every clearing of the flag raises a sticky interrupt, which software clears by writing one. Durations are parameters, so a simulation can shorten them.

Top module: `tune_cmd_ctrl`

## Requirements
- R1: Status codes are 0 = ended OK, 1 = converter limit, 2 = forced end, 3 = busy. After a launch the status is 3 for exactly the selected number of reference ticks, then becomes 0. The durations are set by `cfg_mode` and `cfg_sel`:
  - mode 1 (measurement): T_MEAS
  - mode 2 (adjustment): T_SD when sel is 0 (stereo-decoder calibration), T_IF when sel is 1 (IF calibration)
  - mode 3 (tuning): T_FM when sel is 0 (FM), T_AM when sel is 1 (AM)
- R2: A launch happens on a high-byte write when a low-byte write came earlier and the mode is nonzero. The status is 3 on the next cycle and `cmd_target` = {high, low}. Mode 0 (none), or a high-byte write with no low-byte write since the last high-byte write, launches nothing.
- R3: Only cycles with `ref_tick` high advance the duration count. With no ticks, the status stays 3.
- R4: An abort strobe while the status is 3 sets the status to 2 on the next cycle.
- R5: `dac_limit` high while the status is 3 (and no abort) sets the status to 1 on the next cycle.
- R6: A launch request while the status is 3 is ignored. `cmd_target` keeps its value and the running command finishes at its original time.
- R7: `tuned` becomes 1 when a tuning command (mode 3) ends with status 0. A measurement or adjustment command leaves it unchanged.
- R8: `tuned` is cleared by `radio_pwr` low, by `loop_oor` high, or by the launch of a tuning command. A clear wins over a set in the same cycle.
- R9: `irq` becomes 1 in the same cycle that `tuned` falls from 1 to 0. It never rises when `tuned` rises. It stays 1 until an `irq_clr` pulse.
- R10: After reset, status is 0, `tuned` is 0, `irq` is 0 and `cmd_target` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse for each reference-clock period |
| cfg_wr | input | 1 | Write strobe for command mode and variant |
| cfg_mode | input | 2 | Command class: 0 none, 1 measure, 2 adjust, 3 tune |
| cfg_sel | input | 1 | Variant: adjust 0 stereo/1 IF, tune 0 FM/1 AM |
| tgt_lo_wr | input | 1 | Target low-byte write strobe (arms launch) |
| tgt_hi_wr | input | 1 | Target high-byte write strobe (launches) |
| tgt_data | input | DATA_W | Byte written by either target strobe |
| abort_wr | input | 1 | Abort strobe (identity-register write) |
| dac_limit | input | 1 | Converter-limit indication from the loop |
| loop_oor | input | 1 | Loop outside its correction range |
| radio_pwr | input | 1 | Radio power enable, low means off |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| status | output | 2 | Completion/busy code |
| tuned | output | 1 | Tuned flag |
| irq | output | 1 | Sticky interrupt on tuned clearing |
| cmd_target | output | 2*DATA_W | Target value captured at launch |

## Verification
The assertions assume that the strobes are single-cycle and synchronous, and that every duration parameter is at least one tick. The stimulus therefore raises each strobe for exactly one cycle, drives all inputs one time unit after the rising edge, and uses short but nonzero durations. The converter-limit and abort inputs are raised only at chosen points inside a command, so each early end is reached by one cause alone. The tick input is held low for a stretch to show that the count depends only on ticks.

// File: rtl/tcc_pkg.sv
// Shared types for the timed tuning command controller.
// Assumes: 2-bit encodings are fixed by software-visible fields.
package tcc_pkg;
    typedef enum logic [1:0] {
        CM_NONE = 2'd0,
        CM_MEAS = 2'd1,
        CM_ADJ  = 2'd2,
        CM_TUNE = 2'd3
    } cmd_mode_e;

    typedef enum logic [1:0] {
        ST_OK     = 2'd0,
        ST_DACLIM = 2'd1,
        ST_FORCED = 2'd2,
        ST_BUSY   = 2'd3
    } cmd_status_e;

    function automatic int unsigned max_of5(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d,
                                            input int unsigned e);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction
endpackage

// File: rtl/tcc_launch.sv
// Launch decode: holds the command-mode field, the variant bit and the
// low target byte, arms on a low-byte write and raises a launch request on
// the following high-byte write when a command class is selected.
// Assumes: write strobes are one-cycle pulses in the clk domain.
module tcc_launch
    import tcc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  cmd_mode_e           cfg_mode,
    input  logic                cfg_sel,
    input  logic                tgt_lo_wr,
    input  logic                tgt_hi_wr,
    input  logic [DATA_W-1:0]   tgt_data,
    output cmd_mode_e           mode_q,
    output logic                sel_q,
    output logic                launch_req,
    output logic [2*DATA_W-1:0] tgt_word
);
    logic              armed_q;
    logic [DATA_W-1:0] lo_q;

    // Configuration, low byte and arming state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= CM_NONE;
            sel_q   <= 1'b0;
            armed_q <= 1'b0;
            lo_q    <= '0;
        end else begin
            if (cfg_wr) begin
                mode_q <= cfg_mode;
                sel_q  <= cfg_sel;
            end
            if (tgt_lo_wr) begin
                lo_q    <= tgt_data;
                armed_q <= 1'b1;
            end else if (tgt_hi_wr) begin
                armed_q <= 1'b0;
            end
        end
    end

    // Launch request and the full target word presented with it.
    always_comb begin
        launch_req = tgt_hi_wr && armed_q && (mode_q != CM_NONE);
        tgt_word   = {tgt_data, lo_q};
    end

    // R2: a high-byte write alone always consumes the arming.
    p_hi_disarms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_hi_wr && !tgt_lo_wr) |=> !armed_q);

    // R2: no launch request without a selected class.
    p_no_launch_idle_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch_req |-> (mode_q != CM_NONE) && tgt_hi_wr);
endmodule

// File: rtl/tcc_timer.sv
// Duration timer: picks the execution time for the launched command from
// its class and variant, then counts it down on reference ticks. It pulses
// expire on the tick that completes the last period.
// Assumes: all durations are at least one tick; busy is driven by the owner.
module tcc_timer
    import tcc_pkg::*;
#(
    parameter int unsigned T_MEAS = 3277,
    parameter int unsigned T_SD   = 17695,
    parameter int unsigned T_IF   = 4391,
    parameter int unsigned T_FM   = 3441,
    parameter int unsigned T_AM   = 5177
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cmd_mode_e mode,
    input  logic      sel,
    input  logic      tick,
    input  logic      busy,
    output logic      expire
);
    localparam int unsigned MAX_D = max_of5(T_MEAS, T_SD, T_IF, T_FM, T_AM);
    localparam int          CW    = $clog2(MAX_D + 1);

    logic [CW-1:0] dur_sel;
    logic [CW-1:0] cnt_q;

    // Duration lookup by class and variant.
    always_comb begin
        unique case (mode)
            CM_ADJ:  dur_sel = sel ? CW'(T_IF) : CW'(T_SD);
            CM_TUNE: dur_sel = sel ? CW'(T_AM) : CW'(T_FM);
            default: dur_sel = CW'(T_MEAS);
        endcase
    end

    // Remaining-tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= dur_sel;
        end else if (busy && tick && (cnt_q > CW'(1))) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Completion strobe on the final tick.
    always_comb expire = busy && tick && (cnt_q == CW'(1));

    // R1: a running command always has ticks left to count.
    p_cnt_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0) && (cnt_q <= CW'(MAX_D)));

    // R3: without a tick the count does not move.
    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !load) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/tcc_flags.sv
// Tuned flag and its interrupt. The flag is set by a successful tuning
// completion and cleared by any clear cause (clear wins). The sticky
// interrupt is raised whenever the flag goes from one to zero.
// Assumes: irq_clr is a one-cycle write-one-to-clear pulse.
module tcc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ok,
    input  logic clr_req,
    input  logic irq_clr,
    output logic tuned,
    output logic irq
);
    logic tuned_d;

    // Next value of the tuned flag.
    always_comb begin
        if (clr_req)     tuned_d = 1'b0;
        else if (set_ok) tuned_d = 1'b1;
        else             tuned_d = tuned;
    end

    // Tuned flag and sticky interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tuned <= 1'b0;
            irq   <= 1'b0;
        end else begin
            tuned <= tuned_d;
            if (tuned && !tuned_d) irq <= 1'b1;
            else if (irq_clr)      irq <= 1'b0;
        end
    end

    // R9: the interrupt rises only together with a falling tuned flag.
    p_irq_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(tuned));

    // R9: a rising tuned flag never raises the interrupt.
    p_no_irq_on_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tuned) && !$past(irq)) |-> !irq);

    // R7: the flag rises only after a successful tuning completion.
    p_tuned_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tuned) |-> $past(set_ok));
endmodule

// File: rtl/tune_cmd_ctrl.sv
// Timed tuning command controller top. Takes register-style writes,
// launches one command at a time, runs it for a class-dependent number of
// reference ticks and reports a 2-bit status. Also keeps the tuned flag and
// its interrupt.
// Assumes: strobes are single-cycle; ref_tick is a single-cycle pulse.
module tune_cmd_ctrl
    import tcc_pkg::*;
#(
    parameter int          DATA_W = 8,
    parameter int unsigned T_MEAS = 3277,
    parameter int unsigned T_SD   = 17695,
    parameter int unsigned T_IF   = 4391,
    parameter int unsigned T_FM   = 3441,
    parameter int unsigned T_AM   = 5177
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                cfg_wr,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_sel,
    input  logic                tgt_lo_wr,
    input  logic                tgt_hi_wr,
    input  logic [DATA_W-1:0]   tgt_data,
    input  logic                abort_wr,
    input  logic                dac_limit,
    input  logic                loop_oor,
    input  logic                radio_pwr,
    input  logic                irq_clr,
    output logic [1:0]          status,
    output logic                tuned,
    output logic                irq,
    output logic [2*DATA_W-1:0] cmd_target
);
    cmd_mode_e           mode_q;
    logic                sel_q;
    logic                launch_req;
    logic [2*DATA_W-1:0] tgt_word;
    logic                launch;
    logic                busy;
    logic                expire;
    logic                done_ok;
    logic                tune_set;
    logic                tune_clr;
    cmd_status_e         status_q;
    cmd_mode_e           run_mode_q;
    logic [2*DATA_W-1:0] target_q;

    tcc_launch #(.DATA_W(DATA_W)) u_launch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_mode   (cmd_mode_e'(cfg_mode)),
        .cfg_sel    (cfg_sel),
        .tgt_lo_wr  (tgt_lo_wr),
        .tgt_hi_wr  (tgt_hi_wr),
        .tgt_data   (tgt_data),
        .mode_q     (mode_q),
        .sel_q      (sel_q),
        .launch_req (launch_req),
        .tgt_word   (tgt_word)
    );

    tcc_timer #(
        .T_MEAS (T_MEAS),
        .T_SD   (T_SD),
        .T_IF   (T_IF),
        .T_FM   (T_FM),
        .T_AM   (T_AM)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .mode   (mode_q),
        .sel    (sel_q),
        .tick   (ref_tick),
        .busy   (busy),
        .expire (expire)
    );

    tcc_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ok  (tune_set),
        .clr_req (tune_clr),
        .irq_clr (irq_clr),
        .tuned   (tuned),
        .irq     (irq)
    );

    // Launch gating, completion and tuned-flag causes.
    always_comb begin
        busy     = (status_q == ST_BUSY);
        launch   = launch_req && !busy;
        done_ok  = busy && !abort_wr && !dac_limit && expire;
        tune_set = done_ok && (run_mode_q == CM_TUNE);
        tune_clr = !radio_pwr || loop_oor || (launch && (mode_q == CM_TUNE));
    end

    // Status code with priority abort > converter limit > normal end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= ST_OK;
        end else if (busy) begin
            if (abort_wr)       status_q <= ST_FORCED;
            else if (dac_limit) status_q <= ST_DACLIM;
            else if (expire)    status_q <= ST_OK;
        end else if (launch) begin
            status_q <= ST_BUSY;
        end
    end

    // Capture of the running command's class and target at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_mode_q <= CM_NONE;
            target_q   <= '0;
        end else if (launch) begin
            run_mode_q <= mode_q;
            target_q   <= tgt_word;
        end
    end

    // Output assignment.
    always_comb begin
        status     = status_q;
        cmd_target = target_q;
    end

    // R4: abort during a command forces the end code.
    p_abort_forces_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_wr) |=> (status == 2'd2));

    // R5: converter limit without abort gives the limit code.
    p_limit_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort_wr && dac_limit) |=> (status == 2'd1));

    // R6: a launch request while running leaves the captured target alone.
    p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && launch_req) |=> $stable(cmd_target));

    // R2: a launch from idle always shows busy next.
    p_launch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && launch_req) |=> (status == 2'd3));
endmodule

// File: tb/tune_cmd_ctrl_test.sv
// Scoreboard bench: driver tasks push expected output records into a queue,
// a monitor on the falling edge pops and compares them.
module tune_cmd_ctrl_test;
    localparam int          DW     = 8;
    localparam int unsigned T_MEAS = 6;
    localparam int unsigned T_SD   = 9;
    localparam int unsigned T_IF   = 5;
    localparam int unsigned T_FM   = 4;
    localparam int unsigned T_AM   = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_sel = 1'b0;
    logic          tgt_lo_wr = 1'b0;
    logic          tgt_hi_wr = 1'b0;
    logic [DW-1:0] tgt_data = '0;
    logic          abort_wr = 1'b0;
    logic          dac_limit = 1'b0;
    logic          loop_oor = 1'b0;
    logic          radio_pwr = 1'b1;
    logic          irq_clr = 1'b0;
    logic [1:0]    status;
    logic          tuned;
    logic          irq;
    logic [2*DW-1:0] cmd_target;

    tune_cmd_ctrl #(
        .DATA_W (DW), .T_MEAS (T_MEAS), .T_SD (T_SD),
        .T_IF (T_IF), .T_FM (T_FM), .T_AM (T_AM)
    ) uut (
        .clk (clk), .rst_n (rst_n), .ref_tick (ref_tick),
        .cfg_wr (cfg_wr), .cfg_mode (cfg_mode), .cfg_sel (cfg_sel),
        .tgt_lo_wr (tgt_lo_wr), .tgt_hi_wr (tgt_hi_wr), .tgt_data (tgt_data),
        .abort_wr (abort_wr), .dac_limit (dac_limit), .loop_oor (loop_oor),
        .radio_pwr (radio_pwr), .irq_clr (irq_clr),
        .status (status), .tuned (tuned), .irq (irq), .cmd_target (cmd_target)
    );

    always #5 clk = ~clk;

    typedef struct {
        string           tag;
        logic [1:0]      st;
        logic            tu;
        logic            ir;
        logic [2*DW-1:0] tgt;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    // Expected model, maintained by the script from the requirements.
    logic [1:0]      m_st  = 2'd0;
    logic            m_tu  = 1'b0;
    logic            m_ir  = 1'b0;
    logic [2*DW-1:0] m_tgt = '0;

    // Monitor: compare every queued expectation on the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_tests++;
            if (status !== e.st || tuned !== e.tu || irq !== e.ir || cmd_target !== e.tgt) begin
                n_fail++;
                $display("FAIL %s: got st=%0d tu=%0b irq=%0b tgt=%h, expected st=%0d tu=%0b irq=%0b tgt=%h",
                         e.tag, status, tuned, irq, cmd_target, e.st, e.tu, e.ir, e.tgt);
            end
        end
    end

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string tag);
        exp_t e;
        e.tag = tag; e.st = m_st; e.tu = m_tu; e.ir = m_ir; e.tgt = m_tgt;
        q.push_back(e);
    endtask

    task automatic wr_cfg(input logic [1:0] m, input logic s);
        cfg_wr = 1'b1; cfg_mode = m; cfg_sel = s;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic wr_lo(input logic [DW-1:0] d);
        tgt_lo_wr = 1'b1; tgt_data = d;
        step();
        tgt_lo_wr = 1'b0;
    endtask

    task automatic wr_hi(input logic [DW-1:0] d);
        tgt_hi_wr = 1'b1; tgt_data = d;
        step();
        tgt_hi_wr = 1'b0;
    endtask

    task automatic launch(input logic [1:0] m, input logic s,
                          input logic [DW-1:0] lo, input logic [DW-1:0] hi);
        wr_cfg(m, s);
        wr_lo(lo);
        wr_hi(hi);
    endtask

    task automatic pulse_abort();
        abort_wr = 1'b1; step(); abort_wr = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        irq_clr = 1'b1; step(); irq_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        chk("R10 reset values");
        step();

        // Measurement: launch, duration, no effect on tuned.
        launch(2'd1, 1'b0, 8'h34, 8'h12);
        m_st = 2'd3; m_tgt = 16'h1234;
        chk("R2 launch captures target");
        step(T_MEAS - 1);
        chk("R1 measurement still busy");
        step();
        m_st = 2'd0;
        chk("R1 measurement ends OK, R7 tuned untouched");

        // High byte without a preceding low byte.
        wr_hi(8'h77);
        chk("R2 high write alone ignored");
        step(2);
        chk("R2 still idle after lone high write");

        // Mode 0 selected.
        launch(2'd0, 1'b0, 8'h55, 8'h66);
        chk("R2 mode none does not launch");

        // FM tuning to success.
        launch(2'd3, 1'b0, 8'hCD, 8'hAB);
        m_st = 2'd3; m_tgt = 16'hABCD;
        chk("R2 FM tune launch");
        step(T_FM - 1);
        chk("R1 FM tune busy before end");
        step();
        m_st = 2'd0; m_tu = 1'b1;
        chk("R7 FM tune sets tuned, R9 no irq on set");

        // AM tuning launch clears tuned, then abort.
        launch(2'd3, 1'b1, 8'h02, 8'h01);
        m_st = 2'd3; m_tgt = 16'h0102; m_tu = 1'b0; m_ir = 1'b1;
        chk("R8 new tune clears tuned, R9 irq on fall");
        step(2);
        pulse_abort();
        m_st = 2'd2;
        chk("R4 abort gives forced end");
        step(2);
        chk("R9 irq stays set");
        pulse_irq_clr();
        m_ir = 1'b0;
        chk("R9 irq cleared by write-one");

        // AM tuning to completion.
        launch(2'd3, 1'b1, 8'h10, 8'h20);
        m_st = 2'd3; m_tgt = 16'h2010;
        chk("R2 AM tune launch");
        step(T_AM - 1);
        chk("R1 AM tune busy before end");
        step();
        m_st = 2'd0; m_tu = 1'b1;
        chk("R1 AM tune ends OK, R9 no irq on set");

        // Loop out of range.
        loop_oor = 1'b1; step(); loop_oor = 1'b0;
        m_tu = 1'b0; m_ir = 1'b1;
        chk("R8 out of range clears tuned, R9 irq");
        pulse_irq_clr();
        m_ir = 1'b0;
        chk("R9 irq cleared after out of range");

        // IF calibration with ticks held off.
        launch(2'd2, 1'b1, 8'hEF, 8'hBE);
        m_st = 2'd3; m_tgt = 16'hBEEF;
        ref_tick = 1'b0;
        step(10);
        chk("R3 no ticks, no progress");
        ref_tick = 1'b1;
        step(T_IF - 1);
        chk("R1 IF calibration busy before end");
        step();
        m_st = 2'd0;
        chk("R1 IF calibration ends OK, R7 tuned untouched");

        // Stereo-decoder calibration ended by converter limit.
        launch(2'd2, 1'b0, 8'h11, 8'h22);
        m_st = 2'd3; m_tgt = 16'h2211;
        step(3);
        chk("R1 stereo calibration busy");
        dac_limit = 1'b1; step(); dac_limit = 1'b0;
        m_st = 2'd1;
        chk("R5 converter limit ends command");

        // Start request while busy is ignored.
        launch(2'd1, 1'b0, 8'h01, 8'h01);
        m_st = 2'd3; m_tgt = 16'h0101;
        step(2);
        wr_lo(8'h99);
        wr_hi(8'h88);
        chk("R6 start while busy ignored");
        step();
        chk("R6 still busy on original schedule");
        step();
        m_st = 2'd0;
        chk("R6 ends at original time");

        // Power off clears tuned.
        launch(2'd3, 1'b0, 8'h44, 8'h33);
        m_st = 2'd3; m_tgt = 16'h3344;
        step(T_FM);
        m_st = 2'd0; m_tu = 1'b1;
        chk("R7 FM tune sets tuned again");
        radio_pwr = 1'b0; step(); radio_pwr = 1'b1;
        m_tu = 1'b0; m_ir = 1'b1;
        chk("R8 power off clears tuned, R9 irq");

        step(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule